// File: doc/BRIEF.md
# Strobed Control-Register Port Target

This block is the responder side of a narrow parallel port used to reach a bank of 16-bit diagnostic and override registers. A host drives one shared 16-bit input bus and raises one of four strobes at a time. An address strobe latches the bus as the target offset. A data strobe latches the bus as pending write data. A write strobe copies the pending data into the register at the latched offset. A read strobe places that register on the output bus.

Every strobe is answered with a four-phase handshake. The target raises its acknowledge after a programmable response delay and keeps it high while the strobe stays high. When the strobe goes low, the target drops the acknowledge. The latched offset stays in place across any number of data, write and read phases, so a host can read or rewrite one register many times after addressing it once.

The register bank covers a parameterized window of the 0x0000 to 0x201F offset space. Offsets outside that window read as zero, and writes to them change nothing. If more than one strobe is raised at once, the target reports a protocol error and does not acknowledge.

Top module: `crp_target`

## Requirements
- R1: After reset, `ack` and `proto_err` are 0, `rd_data` is 0x0000, and every implemented register reads back 0x0000.
- R2: When exactly one strobe is raised while the port is idle, `ack` is first seen high after RESP_DLY+1 rising clock edges, counting the first edge that samples the strobe high. The default RESP_DLY is 2, which gives 3 edges.
- R3: `ack` stays high for as long as the strobe that started the phase stays high. It is low after the first rising edge that samples that strobe low.
- R4: A phase on `stb_wr` stores the last value captured by a `stb_data` phase into the register at the last offset captured by a `stb_addr` phase. The capture takes the value of `bus_in` present when `ack` rises.
- R5: A phase on `stb_rd` drives the register at the captured offset on `rd_data`. The value is valid from the cycle `ack` rises and stays stable while `ack` is high.
- R6: The implemented offsets are BASE_OFS to BASE_OFS+NUM_REGS-1, and no higher than 0x201F. The defaults are 0x0000 to 0x000F. A read of any other offset returns 0x0000. A write to any other offset leaves every register unchanged, including the one it would alias to modulo NUM_REGS.
- R7: If two or more strobes are sampled high while the port is idle, `proto_err` goes high and `ack` stays low. `proto_err` clears on the edge after all strobes are sampled low, and the port then accepts new phases.
- R8: A strobe raised while a phase is waiting or acknowledged is ignored. In particular, a data strobe pulsed during an address phase's `ack` does not change the captured data.
- R9: The captured offset persists across any number of data, write and read phases until a new address phase completes.
- R10: If the strobe is dropped before `ack` rises, the phase is abandoned. No `ack` is produced and no capture, write or read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 16 | Shared offset / write data bus |
| stb_addr | input | 1 | Offset capture strobe |
| stb_data | input | 1 | Write data capture strobe |
| stb_wr | input | 1 | Commit strobe |
| stb_rd | input | 1 | Read strobe |
| rd_data | output | 16 | Read result, valid while a read phase is acknowledged |
| ack | output | 1 | Handshake acknowledge |
| proto_err | output | 1 | More than one strobe raised at once |

## Verification
The assertions watch the handshake on every cycle. They check that `ack` rises only while the owning strobe is high, holds while that strobe holds, and falls once the strobe falls. They also check that read data does not move during an acknowledged read, and that a protocol error never coincides with `ack` and always clears once the strobes are released. The values stored in the bank can only be shown by the bench's scenarios: the exact response latency, the persistence of the offset across phases, the aliasing and out-of-window offsets, the strobes ignored mid-phase, and abandoned phases.

// File: rtl/crp_pkg.sv
package crp_pkg;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_WR   = 2'd2,
        PH_RD   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_ERR  = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic addr;
        logic data;
        logic wr;
        logic rd;
    } strobes_t;

    localparam int unsigned OFS_LIMIT = 32'h0000_201F;

    function automatic logic [2:0] strobe_count(strobes_t s);
        return 3'(s.addr) + 3'(s.data) + 3'(s.wr) + 3'(s.rd);
    endfunction

    function automatic phase_e pick_phase(strobes_t s);
        if (s.addr)      return PH_ADDR;
        else if (s.data) return PH_DATA;
        else if (s.wr)   return PH_WR;
        else             return PH_RD;
    endfunction

    function automatic logic strobe_of(strobes_t s, phase_e p);
        case (p)
            PH_ADDR: return s.addr;
            PH_DATA: return s.data;
            PH_WR:   return s.wr;
            default: return s.rd;
        endcase
    endfunction

endpackage

// File: rtl/crp_hs_fsm.sv
module crp_hs_fsm
    import crp_pkg::*;
#(
    parameter int unsigned RESP_DLY = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  strobes_t stb,
    output logic     ack,
    output logic     proto_err,
    output logic     fire,
    output phase_e   phase
);
    localparam int unsigned CNT_W = (RESP_DLY > 1) ? $clog2(RESP_DLY) : 1;

    hs_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic             own_stb;

    assign own_stb   = strobe_of(stb, phase);
    // Action happens on the same edge that moves the FSM into ST_ACK
    assign fire      = (st == ST_WAIT) && own_stb && (cnt == '0);
    assign ack       = (st == ST_ACK);
    assign proto_err = (st == ST_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            phase <= PH_ADDR;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (strobe_count(stb) > 3'd1) begin
                        st <= ST_ERR;
                    end else if (strobe_count(stb) == 3'd1) begin
                        phase <= pick_phase(stb);
                        cnt   <= CNT_W'(RESP_DLY - 1);
                        st    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!own_stb)          st  <= ST_IDLE;
                    else if (cnt == '0)    st  <= ST_ACK;
                    else                   cnt <= cnt - 1'b1;
                end
                ST_ACK: begin
                    if (!own_stb) st <= ST_IDLE;
                end
                default: begin
                    if (stb == '0) st <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/crp_capture.sv
module crp_capture
    import crp_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (fire) begin
            if (phase == PH_ADDR) addr_q <= bus;
            if (phase == PH_DATA) data_q <= bus;
        end
    end
endmodule

// File: rtl/crp_regbank.sv
module crp_regbank
    import crp_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned BASE_OFS = 0,
    parameter int unsigned NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int unsigned TOP   = BASE_OFS + NUM_REGS - 1;

    logic [DATA_W-1:0] bank [NUM_REGS];
    logic [31:0]       a32;
    logic [31:0]       rel;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_sel;
    logic              we;

    assign a32 = 32'(addr);
    assign rel = a32 - BASE_OFS;
    assign hit = (a32 >= BASE_OFS) && (a32 <= TOP) && (a32 <= OFS_LIMIT);
    assign idx = IDX_W'(rel);
    assign we  = fire && (phase == PH_WR) && hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                         bank[g] <= '0;
            else if (we && (32'(idx) == g))  bank[g] <= wdata;
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit && (32'(idx) == i)) rd_sel = bank[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             rdata <= '0;
        else if (fire && (phase == PH_RD))   rdata <= rd_sel;
    end
endmodule

// File: rtl/crp_target.sv
module crp_target
    import crp_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned BASE_OFS = 0,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned RESP_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              stb_addr,
    input  logic              stb_data,
    input  logic              stb_wr,
    input  logic              stb_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack,
    output logic              proto_err
);
    strobes_t          stb;
    logic              fire;
    phase_e            cur_phase;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign stb = '{addr: stb_addr, data: stb_data, wr: stb_wr, rd: stb_rd};

    crp_hs_fsm #(.RESP_DLY(RESP_DLY)) u_fsm (
        .clk(clk), .rst(rst), .stb(stb), .ack(ack),
        .proto_err(proto_err), .fire(fire), .phase(cur_phase)
    );

    crp_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .fire(fire), .phase(cur_phase),
        .bus(bus_in), .addr_q(addr_q), .data_q(data_q)
    );

    crp_regbank #(.DATA_W(DATA_W), .BASE_OFS(BASE_OFS), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .fire(fire), .phase(cur_phase),
        .addr(addr_q), .wdata(data_q), .rdata(rd_data)
    );
endmodule

// File: rtl/crp_target_chk.sv
module crp_target_chk
    import crp_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              stb_addr,
    input logic              stb_data,
    input logic              stb_wr,
    input logic              stb_rd,
    input logic              ack,
    input logic              proto_err,
    input logic [DATA_W-1:0] rd_data,
    input phase_e            cur_phase
);
    logic own;
    logic any_stb;

    always_comb begin
        case (cur_phase)
            PH_ADDR: own = stb_addr;
            PH_DATA: own = stb_data;
            PH_WR:   own = stb_wr;
            default: own = stb_rd;
        endcase
    end
    assign any_stb = stb_addr | stb_data | stb_wr | stb_rd;

    // R2
    ack_rise_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(own));

    // R3
    ack_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && own) |=> ack);

    // R3
    ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !own) |=> !ack);

    // R5
    rd_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack) && cur_phase == PH_RD) |-> $stable(rd_data));

    // R7
    err_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !ack);

    // R7
    err_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (proto_err && !any_stb) |=> !proto_err);
endmodule

bind crp_target crp_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .stb_addr(stb_addr), .stb_data(stb_data),
    .stb_wr(stb_wr), .stb_rd(stb_rd), .ack(ack), .proto_err(proto_err),
    .rd_data(rd_data), .cur_phase(cur_phase)
);

// File: tb/crp_target_tb.sv
module crp_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_in = '0;
    logic        stb_addr = 1'b0, stb_data = 1'b0, stb_wr = 1'b0, stb_rd = 1'b0;
    logic [15:0] rd_data;
    logic        ack, proto_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crp_target #(.DATA_W(16), .BASE_OFS(0), .NUM_REGS(16), .RESP_DLY(DLY)) u_dut (
        .clk(clk), .rst(rst), .bus_in(bus_in), .stb_addr(stb_addr),
        .stb_data(stb_data), .stb_wr(stb_wr), .stb_rd(stb_rd),
        .rd_data(rd_data), .ack(ack), .proto_err(proto_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_stb(input int kind, input logic v);
        case (kind)
            0: stb_addr = v;
            1: stb_data = v;
            2: stb_wr   = v;
            default: stb_rd = v;
        endcase
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    // Full four-phase handshake; kind 0 addr, 1 data, 2 write, 3 read
    task automatic phase(input int kind, input logic [15:0] val, output logic [15:0] rd);
        int lat = 0;
        bus_in = val;
        set_stb(kind, 1'b1);
        while (!ack && lat < 20) begin tick(); lat++; end
        chk("R2 ack latency", lat, DLY + 1);
        rd = rd_data;
        tick();
        chk("R3 ack held", ack, 1);
        chk("R5 read stable", rd_data, rd);
        set_stb(kind, 1'b0);
        tick();
        chk("R3 ack released", ack, 0);
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] x;
        phase(0, a, x); phase(1, d, x); phase(2, 16'h0, x);
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [15:0] d);
        logic [15:0] x;
        phase(0, a, x); phase(3, 16'h0, d);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 ack", ack, 0);
        chk("R1 proto_err", proto_err, 0);
        chk("R1 rd_data", rd_data, 0);
        rd_reg(16'h0003, v);
        chk("R1 reg reset", v, 0);
    endtask

    task automatic t_write_read();
        logic [15:0] v;
        wr_reg(16'h0005, 16'hA5A5);
        rd_reg(16'h0005, v);
        chk("R4 write/read", v, 16'hA5A5);
        wr_reg(16'h000F, 16'h0F0F);
        rd_reg(16'h000F, v);
        chk("R5 top reg", v, 16'h0F0F);
    endtask

    task automatic t_persist();
        logic [15:0] v, x;
        phase(0, 16'h0007, x);
        phase(1, 16'h1111, x); phase(2, 0, x);
        phase(1, 16'h2222, x); phase(2, 0, x);
        phase(3, 0, v);
        chk("R9 addr persist", v, 16'h2222);
        phase(3, 0, v);
        chk("R9 repeat read", v, 16'h2222);
        rd_reg(16'h0008, v);
        chk("R9 neighbour untouched", v, 0);
    endtask

    task automatic t_window();
        logic [15:0] v;
        wr_reg(16'h0010, 16'hBEEF);
        rd_reg(16'h0000, v);
        chk("R6 no alias write", v, 0);
        rd_reg(16'h0010, v);
        chk("R6 unimpl read", v, 0);
        wr_reg(16'h201F, 16'h1234);
        rd_reg(16'h201F, v);
        chk("R6 far offset", v, 0);
    endtask

    task automatic t_multi();
        logic [15:0] v;
        bus_in = 16'h0005;
        stb_addr = 1'b1; stb_data = 1'b1;
        repeat (5) tick();
        chk("R7 no ack", ack, 0);
        chk("R7 err set", proto_err, 1);
        stb_addr = 1'b0; stb_data = 1'b0;
        tick();
        chk("R7 err cleared", proto_err, 0);
        rd_reg(16'h0005, v);
        chk("R7 port usable", v, 16'hA5A5);
    endtask

    task automatic t_busy();
        logic [15:0] v, x;
        phase(1, 16'h1234, x);
        bus_in = 16'h0009;
        stb_addr = 1'b1;
        while (!ack) tick();
        bus_in = 16'hDEAD; stb_data = 1'b1;
        tick();
        stb_data = 1'b0;
        tick();
        stb_addr = 1'b0;
        tick();
        phase(2, 0, x);
        rd_reg(16'h0009, v);
        chk("R8 stray strobe ignored", v, 16'h1234);
    endtask

    task automatic t_abort();
        logic [15:0] v, x;
        phase(0, 16'h0009, x);
        phase(1, 16'h7777, x);
        stb_wr = 1'b1;
        tick();
        stb_wr = 1'b0;
        repeat (4) begin
            tick();
            chk("R10 no ack", ack, 0);
        end
        phase(3, 0, v);
        chk("R10 no write", v, 16'h1234);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_write_read();
        t_persist();
        t_window();
        t_multi();
        t_busy();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule